// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and the banked memories of a plug-in cartridge. Writes the processor aims at the read-only program space never reach the ROM. They are decoded as updates to four small control fields: a RAM enable latch, a 5-bit low ROM bank field, a shared 2-bit field, and a banking-mode latch. Reads of the lower 16 KiB window always reach ROM bank 0. Reads of the upper 16 KiB window reach the selected bank, and the block drives a 21-bit physical ROM address for them.

The shared 2-bit field is routed by the mode latch. A mode state machine has two states: ROMBANK and RAMBANK. It moves from ROMBANK to RAMBANK on a mode write with data bit 0 set. It moves from RAMBANK to ROMBANK on a mode write with data bit 0 clear. In ROMBANK the 2-bit field supplies ROM bank bits 6:5. In RAMBANK it supplies the external RAM page number. External RAM occupies an 8 KiB window and is split into up to four pages. The block drives a 15-bit physical RAM address for it. While RAM is disabled, that window reads as 0xFF and no RAM strobe is raised.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the selected ROM bank is 1, the RAM page is 0, RAM is disabled and the mode state is ROMBANK.
- R2: A write to 0x0000–0x1FFF enables RAM when data bits 3:0 equal 0xA and disables it for any other value.
- R3: A write to 0x2000–0x3FFF loads data bits 4:0 into ROM bank bits 4:0. A value of 0 there is stored as 1.
- R4: A write to 0x2000–0x3FFF leaves ROM bank bits 6:5 unchanged.
- R5: In ROMBANK, a write to 0x4000–0x5FFF loads data bits 1:0 into ROM bank bits 6:5 and leaves the RAM page unchanged.
- R6: In RAMBANK, a write to 0x4000–0x5FFF loads data bits 1:0 into the RAM page and leaves the ROM bank unchanged.
- R7: A write to 0x6000–0x7FFF selects RAMBANK when data bit 0 is 1 and ROMBANK when it is 0. The other data bits are ignored.
- R8: A read of 0x0000–0x3FFF drives rom_addr = address (bank 0) and asserts rom_rd.
- R9: A read of 0x4000–0x7FFF drives rom_addr = bank × 0x4000 + (address − 0x4000).
- R10: An access to 0xA000–0xBFFF with RAM enabled drives ram_addr = page × 0x2000 + (address − 0xA000), with ram_rd or ram_wr asserted and cpu_rdata = ram_rdata on reads.
- R11: With RAM disabled, reads of 0xA000–0xBFFF return 0xFF and neither ram_rd nor ram_wr is asserted.
- R12: A control write takes effect at the clock edge that samples it. A read in the very next cycle sees the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data returned to the processor |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_rd | output | 1 | ROM read enable |
| rom_rdata | input | 8 | ROM data |
| ram_addr | output | 15 | Physical external RAM byte address |
| ram_rd | output | 1 | External RAM read enable |
| ram_wr | output | 1 | External RAM write enable |
| ram_wdata | output | 8 | External RAM write data |
| ram_rdata | input | 8 | External RAM data |

## Verification
The assertions check several properties on every cycle:
- the fixed window always lands in bank 0;
- the switchable window never shows a zero low bank field;
- ROM and RAM offsets pass through unchanged;
- a disabling write removes every RAM strobe in the following cycle;
- the disabled RAM window reads 0xFF;
- the upper bank bits hold still across back-to-back reads with no write between them.

The directed scenarios are needed for the rest:
- the routing of the shared 2-bit field under each mode;
- the zero-to-one substitution;
- the preservation of bits 6:5 on a low-field write;
- the next-cycle visibility of each control write.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int ROM_OFF_W = 14;
    localparam int RAM_OFF_W = 13;

    typedef enum logic [1:0] {
        SEL_RAM_EN  = 2'b00,
        SEL_BANK_LO = 2'b01,
        SEL_SHARED  = 2'b10,
        SEL_MODE    = 2'b11
    } ctrl_sel_e;

    typedef enum logic {
        ROMBANK = 1'b0,
        RAMBANK = 1'b1
    } bank_mode_e;

    localparam logic [3:0] RAM_KEY = 4'hA;
endpackage

// File: rtl/cbc_ctrl_regs.sv
module cbc_ctrl_regs
    import cbc_pkg::*;
#(
    parameter int LO_W = 5,
    parameter int HI_W = 2,
    parameter int PG_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [DATA_W-1:0]    wdata,
    output logic [LO_W+HI_W-1:0] rom_bank,
    output logic [PG_W-1:0]      ram_page,
    output logic                 ram_en
);
    localparam int BANK_W = LO_W + HI_W;

    bank_mode_e      state_q, state_d;
    logic [LO_W-1:0] lo_q, lo_d;
    logic [HI_W-1:0] hi_q, hi_d;
    logic [PG_W-1:0] pg_q, pg_d;
    logic            en_q, en_d;
    logic [LO_W-1:0] lo_raw;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:LO_W];

    assign lo_raw = wdata[LO_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ROMBANK;
            lo_q    <= LO_W'(1);
            hi_q    <= '0;
            pg_q    <= '0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            lo_q    <= lo_d;
            hi_q    <= hi_d;
            pg_q    <= pg_d;
            en_q    <= en_d;
        end
    end

    always_comb begin
        state_d = state_q;
        lo_d    = lo_q;
        hi_d    = hi_q;
        pg_d    = pg_q;
        en_d    = en_q;
        if (wr_en) begin
            unique case (ctrl_sel_e'(wr_sel))
                SEL_RAM_EN:  en_d = (wdata[3:0] == RAM_KEY);
                SEL_BANK_LO: lo_d = (lo_raw == '0) ? LO_W'(1) : lo_raw;
                SEL_SHARED: begin
                    unique case (state_q)
                        ROMBANK: hi_d = wdata[HI_W-1:0];
                        RAMBANK: pg_d = wdata[PG_W-1:0];
                    endcase
                end
                SEL_MODE: begin
                    unique case (state_q)
                        ROMBANK: if (wdata[0])  state_d = RAMBANK;
                        RAMBANK: if (!wdata[0]) state_d = ROMBANK;
                    endcase
                end
            endcase
        end
    end

    always_comb begin
        rom_bank = BANK_W'({hi_q, lo_q});
        ram_page = pg_q;
        ram_en   = en_q;
    end
endmodule

// File: rtl/cbc_rom_map.sv
module cbc_rom_map
    import cbc_pkg::*;
#(
    parameter int BANK_W = 7
) (
    input  logic [CPU_AW-1:0]           addr,
    input  logic                        rd,
    input  logic [BANK_W-1:0]           bank,
    output logic [BANK_W+ROM_OFF_W-1:0] rom_addr,
    output logic                        rom_rd,
    output logic                        in_rom
);
    logic [BANK_W-1:0] eff_bank;

    always_comb begin
        in_rom   = (addr[CPU_AW-1] == 1'b0);
        eff_bank = addr[ROM_OFF_W] ? bank : '0;
        rom_addr = {eff_bank, addr[ROM_OFF_W-1:0]};
        rom_rd   = rd && in_rom;
    end
endmodule

// File: rtl/cbc_ram_map.sv
module cbc_ram_map
    import cbc_pkg::*;
#(
    parameter int PG_W = 2
) (
    input  logic [CPU_AW-1:0]         addr,
    input  logic                      rd,
    input  logic                      wr,
    input  logic [PG_W-1:0]           page,
    input  logic                      enable,
    output logic [PG_W+RAM_OFF_W-1:0] ram_addr,
    output logic                      ram_rd,
    output logic                      ram_wr,
    output logic                      in_ram
);
    always_comb begin
        in_ram   = (addr[CPU_AW-1:RAM_OFF_W] == 3'b101);
        ram_addr = {page, addr[RAM_OFF_W-1:0]};
        ram_rd   = rd && in_ram && enable;
        ram_wr   = wr && in_ram && enable;
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int LO_W = 5,
    parameter int HI_W = 2,
    parameter int PG_W = 2,
    localparam int BANK_W = LO_W + HI_W,
    localparam int ROM_AW = BANK_W + ROM_OFF_W,
    localparam int RAM_AW = PG_W + RAM_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [7:0]        cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_rd,
    input  logic [7:0]        rom_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    logic [BANK_W-1:0] rom_bank;
    logic [PG_W-1:0]   ram_page;
    logic              ram_en;
    logic              in_rom, in_ram;
    logic              ctrl_wr;

    assign ctrl_wr = cpu_wr && (cpu_addr[15] == 1'b0);

    cbc_ctrl_regs #(.LO_W(LO_W), .HI_W(HI_W), .PG_W(PG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wr_sel   (cpu_addr[14:13]),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank),
        .ram_page (ram_page),
        .ram_en   (ram_en)
    );

    cbc_rom_map #(.BANK_W(BANK_W)) u_rom (
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .bank     (rom_bank),
        .rom_addr (rom_addr),
        .rom_rd   (rom_rd),
        .in_rom   (in_rom)
    );

    cbc_ram_map #(.PG_W(PG_W)) u_ram (
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .wr       (cpu_wr),
        .page     (ram_page),
        .enable   (ram_en),
        .ram_addr (ram_addr),
        .ram_rd   (ram_rd),
        .ram_wr   (ram_wr),
        .in_ram   (in_ram)
    );

    always_comb begin
        ram_wdata = cpu_wdata;
        if (in_rom)      cpu_rdata = rom_rdata;
        else if (ram_rd) cpu_rdata = ram_rdata;
        else             cpu_rdata = 8'hFF;
    end
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_rdata,
    input logic [20:0] rom_addr,
    input logic        ram_rd,
    input logic        ram_wr,
    input logic [14:0] ram_addr
);
    p_rom_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:14] == 2'b00) |-> (rom_addr[20:14] == 7'd0));

    p_bank_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:14] == 2'b01) |-> (rom_addr[18:14] != 5'd0));

    p_rom_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15] == 1'b0) |-> (rom_addr[13:0] == cpu_addr[13:0]));

    p_ram_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd || ram_wr) |-> (ram_addr[12:0] == cpu_addr[12:0] && cpu_addr[15:13] == 3'b101));

    p_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA) |=> (!ram_rd && !ram_wr));

    p_ff_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:13] == 3'b101 && !ram_rd) |-> (cpu_rdata == 8'hFF));

    p_hi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:14] == 2'b01 && $past(cpu_rd && !cpu_wr && cpu_addr[15:14] == 2'b01))
        |-> (rom_addr[20:14] == $past(rom_addr[20:14])));
endmodule

bind cart_bank_ctrl cbc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr),
    .ram_addr  (ram_addr)
);

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [20:0] rom_addr;
    logic        rom_rd;
    logic [7:0]  rom_rdata = 8'h3E;
    logic [14:0] ram_addr;
    logic        ram_rd;
    logic        ram_wr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = 8'h5C;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cart_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_rdata(rom_rdata),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [15:0] a);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        rd_now(a);
    endtask

    function automatic logic [20:0] rom_exp(input int bank, input logic [15:0] a);
        return 21'(bank * 32'h4000 + (a - 16'h4000));
    endfunction

    task automatic t_reset_state();
        rd(16'h4000); check("R1 bank", rom_addr, rom_exp(1, 16'h4000));
        rd(16'hA010); check("R1 ram off", cpu_rdata, 8'hFF);
        check("R1 no ram_rd", ram_rd, 0);
        wr(16'h0000, 8'h0A);
        rd(16'hA010); check("R1 page 0", ram_addr, 15'h0010);
        wr(16'h4000, 8'h02);
        rd(16'h4000); check("R1 ROMBANK mode", rom_addr, rom_exp(7'h41, 16'h4000));
        wr(16'h4000, 8'h00); wr(16'h0000, 8'h00);
    endtask

    task automatic t_ram_enable();
        wr(16'h1FFF, 8'h1A);
        rd(16'hA000); check("R2 enable 0x1A", ram_rd, 1);
        check("R10 rdata", cpu_rdata, 8'h5C);
        wr(16'h0100, 8'h0B);
        rd(16'hA000); check("R2 disable 0x0B", ram_rd, 0);
        wr(16'h0000, 8'hFA);
        rd(16'hA000); check("R2 enable 0xFA", ram_rd, 1);
        wr(16'h0000, 8'hA0);
        rd(16'hA000); check("R2 disable 0xA0", ram_rd, 0);
    endtask

    task automatic t_bank_low();
        wr(16'h2000, 8'h00);
        rd(16'h4000); check("R3 zero->1", rom_addr, rom_exp(1, 16'h4000));
        wr(16'h3FFF, 8'h20);
        rd(16'h4000); check("R3 masked zero->1", rom_addr, rom_exp(1, 16'h4000));
        wr(16'h2000, 8'hF5);
        rd(16'h4000); check("R3 low 0x15", rom_addr, rom_exp(8'h15, 16'h4000));
        wr(16'h4000, 8'h03);
        wr(16'h2000, 8'h07);
        rd(16'h7FFF); check("R4 hi kept", rom_addr, rom_exp(8'h67, 16'h7FFF));
    endtask

    task automatic t_shared_modes();
        wr(16'h0000, 8'h0A);
        wr(16'h5FFF, 8'h01);
        rd(16'h4000); check("R5 hi=1", rom_addr, rom_exp(8'h27, 16'h4000));
        rd(16'hA123); check("R5 page kept", ram_addr, 15'h0123);
        wr(16'h6000, 8'h01);
        wr(16'h4000, 8'h02);
        rd(16'hA123); check("R6 page 2", ram_addr, 15'h4123);
        rd(16'h4000); check("R6 bank kept", rom_addr, rom_exp(8'h27, 16'h4000));
        wr(16'h7FFF, 8'hFE);
        wr(16'h4000, 8'h03);
        rd(16'h4000); check("R7 bit0=0 ROMBANK", rom_addr, rom_exp(8'h67, 16'h4000));
        rd(16'hB000); check("R7 page kept", ram_addr, 15'h5000);
        wr(16'h6000, 8'h03);
        wr(16'h4000, 8'h01);
        rd(16'hBFFF); check("R10 page 1 top", ram_addr, 15'h3FFF);
        wr(16'h6000, 8'h00);
    endtask

    task automatic t_windows();
        rd(16'h0000); check("R8 fixed low", rom_addr, 21'h0);
        check("R8 rom_rd", rom_rd, 1);
        rd(16'h3FFF); check("R8 fixed top", rom_addr, 21'h3FFF);
        check("R8 data", cpu_rdata, 8'h3E);
        rd(16'h5555); check("R9 switch", rom_addr, rom_exp(8'h67, 16'h5555));
    endtask

    task automatic t_ram_disabled();
        wr(16'h0000, 8'h00);
        rd(16'hA555); check("R11 ff", cpu_rdata, 8'hFF);
        check("R11 no rd", ram_rd, 0);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'hA555; cpu_wdata = 8'h77; cpu_wr = 1'b1;
        #1; check("R11 no wr", ram_wr, 0);
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic t_next_cycle();
        @(negedge clk);
        cpu_addr = 16'h2000; cpu_wdata = 8'h09; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        rd_now(16'h4000); check("R12 next cycle bank", rom_addr, rom_exp(8'h69, 16'h4000));
        wr(16'h0000, 8'h0A);
        rd_now(16'hA001); check("R12 next cycle enable", ram_rd, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_ram_enable();
        t_bank_low();
        t_shared_modes();
        t_windows();
        t_ram_disabled();
        t_next_cycle();
        @(negedge clk); cpu_rd = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule